// File: doc/BRIEF.md
# In-Memory Adder Instruction Sequencer

This controller drives a computational resistive memory through an n-bit addition of two words that are already stored in the array. It has no adder gates of its own. The sum comes from in-memory XOR steps and the carry from bit-wise majority steps, and the controller's only job is to issue those array instructions in the right order with the right addresses. A run takes 2N+2 instruction cycles.

The array is organised as two sub-arrays. Three word addresses are fixed by parameters: the partial-sum word and the carry word in the second sub-array, and the carry-in word in the first sub-array. A start pulse latches the two operand addresses and the result address. The sequence then runs as follows:

- One write step clears both the carry word and the carry-in word.
- The operands are XORed into the partial-sum word.
- For each bit, a majority step writes the carry into the next bit of the carry word.
- Each new carry bit except the last is copied back into the carry-in word, so that the next majority finds all three inputs in one sub-array.
- A final XOR of the partial sum with the carry word writes the result word.

Each instruction is shown on the bus for exactly one cycle, with `ins_valid` high. `done` pulses for one cycle after the last instruction.

Top module: `imadd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `ins_valid` are 0, and every instruction field reads 0.
- R2: When `start` is seen at a clock edge while idle, `busy` and `ins_valid` rise at that edge. Exactly 2N+2 instructions follow, one per cycle, on consecutive cycles. Every field not named for a step in R3 to R7 reads 0.
- R3: Step 0 is the clear step. It has code 1000 and mode 0, with shift 000 and bit-select 0. Its destination is the carry word and its second destination is the carry-in word.
- R4: Step 1 has code 0100, mode 1 and shift 000, and it is word-wide (bit-select 0). Its destination is the partial-sum word, source 0 is operand A and source 1 is operand B.
- R5: Step 2+2i (i = 0..N-1) is the majority step for bit i. It has code 0100's sibling code 0010, mode 1, shift 001 and bit-select 1, with bit index i. Its destination is the carry word. Its sources are A, B and the carry-in word, as source 0, 1 and 2.
- R6: Step 3+2i (i = 0..N-2) is the copy-back step. It has code 0000, mode 1, shift 000 and bit-select 1, with bit index i+1. Its destination is the carry-in word and source 0 is the carry word.
- R7: Step 2N+1 has code 0100, mode 1 and shift 000, and it is word-wide. Its destination is the result word, source 0 is the partial-sum word and source 1 is the carry word.
- R8: In the cycle after the last instruction, `done` is 1 and `ins_valid` and `busy` are 0. In the cycle after that, `done` is 0 again.
- R9: A `start` pulse while busy is ignored. The running sequence keeps its latched addresses and its length.
- R10: A `start` pulse in the `done` cycle is accepted, and a new sequence begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an addition |
| op_a_addr | input | AW | Word address of operand A |
| op_b_addr | input | AW | Word address of operand B |
| res_addr | input | AW | Word address of the result |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ins_valid | output | 1 | Instruction bus holds a step |
| ins_code | output | 4 | Sense-amplifier control code |
| ins_mode | output | 1 | Mode select (0 external write, 1 internal) |
| ins_shift | output | 3 | Shift applied to the output bit |
| ins_bitsel | output | 1 | 1 for a single-bit step |
| ins_bit | output | BW | Bit index for a single-bit step |
| ins_dst | output | AW | Destination word |
| ins_dst2 | output | AW | Second destination (clear step only) |
| ins_src0 | output | AW | Source word 0 |
| ins_src1 | output | AW | Source word 1 |
| ins_src2 | output | AW | Source word 2 (majority only) |

## Verification
Two events can fall in the same cycle: the `done` pulse of one run and the acceptance of a new `start`. A start can also arrive on top of a run that is still in progress. The bench raises `start` exactly in the `done` cycle and checks that a complete new sequence, with the new addresses, follows without a gap. In another run it raises `start` with different addresses in the middle of a sequence. It then checks that every later step still carries the original addresses and that `done` comes after exactly 2N+2 steps.

// File: rtl/imadd_seq.sv
module imadd_seq #(
  parameter int N = 8,
  parameter int AW = 6,
  parameter logic [AW-1:0] PSUM_ADDR = 6'd20,
  parameter logic [AW-1:0] CARRY_ADDR = 6'd21,
  parameter logic [AW-1:0] CIN_ADDR = 6'd22,
  localparam int BW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(2*N+2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] op_a_addr,
  input  logic [AW-1:0] op_b_addr,
  input  logic [AW-1:0] res_addr,
  output logic          busy,
  output logic          done,
  output logic          ins_valid,
  output logic [3:0]    ins_code,
  output logic          ins_mode,
  output logic [2:0]    ins_shift,
  output logic          ins_bitsel,
  output logic [BW-1:0] ins_bit,
  output logic [AW-1:0] ins_dst,
  output logic [AW-1:0] ins_dst2,
  output logic [AW-1:0] ins_src0,
  output logic [AW-1:0] ins_src1,
  output logic [AW-1:0] ins_src2
);
  localparam logic [CW-1:0] LAST = CW'(2*N+1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q, b_q, r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      a_q  <= '0;
      b_q  <= '0;
      r_q  <= '0;
    end else begin
      done <= busy && (cnt == LAST);
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          a_q  <= op_a_addr;
          b_q  <= op_b_addr;
          r_q  <= res_addr;
        end
      end else if (cnt == LAST) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic [CW-1:0] k, bidx;
  logic is_clr, is_x1, is_fin, is_mid, is_maj, is_cpy;

  assign k      = cnt - CW'(2);
  assign is_clr = (cnt == '0);
  assign is_x1  = (cnt == CW'(1));
  assign is_fin = (cnt == LAST);
  assign is_mid = !is_clr && !is_x1 && !is_fin;
  assign is_maj = is_mid && !k[0];
  assign is_cpy = is_mid && k[0];
  assign bidx   = (k >> 1) + CW'(is_cpy);
  assign ins_valid = busy;

  always_comb begin
    ins_code   = '0;
    ins_mode   = 1'b0;
    ins_shift  = '0;
    ins_bitsel = 1'b0;
    ins_bit    = '0;
    ins_dst    = '0;
    ins_dst2   = '0;
    ins_src0   = '0;
    ins_src1   = '0;
    ins_src2   = '0;
    if (busy) begin
      if (is_clr) begin
        ins_code = 4'b1000;
        ins_dst  = CARRY_ADDR;
        ins_dst2 = CIN_ADDR;
      end else if (is_x1) begin
        ins_code = 4'b0100;
        ins_mode = 1'b1;
        ins_dst  = PSUM_ADDR;
        ins_src0 = a_q;
        ins_src1 = b_q;
      end else if (is_fin) begin
        ins_code = 4'b0100;
        ins_mode = 1'b1;
        ins_dst  = r_q;
        ins_src0 = PSUM_ADDR;
        ins_src1 = CARRY_ADDR;
      end else if (is_maj) begin
        ins_code   = 4'b0010;
        ins_mode   = 1'b1;
        ins_shift  = 3'b001;
        ins_bitsel = 1'b1;
        ins_bit    = bidx[BW-1:0];
        ins_dst    = CARRY_ADDR;
        ins_src0   = a_q;
        ins_src1   = b_q;
        ins_src2   = CIN_ADDR;
      end else begin
        ins_mode   = 1'b1;
        ins_bitsel = 1'b1;
        ins_bit    = bidx[BW-1:0];
        ins_dst    = CIN_ADDR;
        ins_src0   = CARRY_ADDR;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ins_valid); // R8
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (ins_code == 4'b1000 && !ins_mode)); // R3
  AST_MAJ_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (ins_valid && ins_code == 4'b0010) |=> (ins_valid && (ins_code == 4'b0000 || ins_code == 4'b0100))); // R5
  AST_END_XOR: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done && $past(ins_code) == 4'b0100)); // R7
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && cnt != LAST) |=> busy); // R9
endmodule

// File: tb/tb_imadd_seq.sv
`timescale 1ns/1ps
module tb_imadd_seq;
  localparam int N = 8;
  localparam int AW = 6;
  localparam int BW = $clog2(N);
  localparam int STEPS = 2*N+2;
  localparam logic [AW-1:0] PS = 6'd20, CY = 6'd21, CI = 6'd22;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] a_in = '0, b_in = '0, r_in = '0;
  logic busy, done, ins_valid, ins_mode, ins_bitsel;
  logic [3:0] ins_code;
  logic [2:0] ins_shift;
  logic [BW-1:0] ins_bit;
  logic [AW-1:0] ins_dst, ins_dst2, ins_src0, ins_src1, ins_src2;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  imadd_seq #(.N(N), .AW(AW), .PSUM_ADDR(PS), .CARRY_ADDR(CY), .CIN_ADDR(CI)) dut (
    .clk, .rst_n, .start, .op_a_addr(a_in), .op_b_addr(b_in), .res_addr(r_in),
    .busy, .done, .ins_valid, .ins_code, .ins_mode, .ins_shift, .ins_bitsel,
    .ins_bit, .ins_dst, .ins_dst2, .ins_src0, .ins_src1, .ins_src2);

  localparam logic [3*AW-1:0] VEC [4] = '{
    {6'd1, 6'd2, 6'd3}, {6'd0, 6'd63, 6'd8}, {6'd40, 6'd41, 6'd40}, {6'd17, 6'd17, 6'd33}};

  function automatic logic [63:0] bus_now();
    return 64'({ins_valid, ins_code, ins_mode, ins_shift, ins_bitsel, ins_bit,
                ins_dst, ins_dst2, ins_src0, ins_src1, ins_src2});
  endfunction

  function automatic logic [63:0] mk(logic v, logic [3:0] c, logic m, logic [2:0] sh, logic bs,
      logic [BW-1:0] bi, logic [AW-1:0] d, d2, s0, s1, s2);
    return 64'({v, c, m, sh, bs, bi, d, d2, s0, s1, s2});
  endfunction

  function automatic logic [63:0] expect_step(int s, logic [AW-1:0] a, b, r);
    int m;
    if (s == 0) return mk(1, 4'b1000, 0, 3'b000, 0, '0, CY, CI, '0, '0, '0);
    if (s == 1) return mk(1, 4'b0100, 1, 3'b000, 0, '0, PS, '0, a, b, '0);
    if (s == STEPS-1) return mk(1, 4'b0100, 1, 3'b000, 0, '0, r, '0, PS, CY, '0);
    m = s - 2;
    if (m % 2 == 0) return mk(1, 4'b0010, 1, 3'b001, 1, BW'(m/2), CY, '0, a, b, CI);
    return mk(1, 4'b0000, 1, 3'b000, 1, BW'(m/2 + 1), CI, '0, CY, '0, '0);
  endfunction

  function automatic string tag_of(int s);
    if (s == 0) return "R3";
    if (s == 1) return "R4";
    if (s == STEPS-1) return "R7";
    if ((s - 2) % 2 == 0) return "R5";
    return "R6";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at the negedge where step 0 is visible; returns at the done negedge.
  task automatic steps(logic [AW-1:0] a, b, r, int inj);
    for (int s = 0; s < STEPS; s++) begin
      check(tag_of(s), bus_now(), expect_step(s, a, b, r));
      check("R2", 64'(busy), 64'(1));
      if (s == inj) begin
        start = 1'b1; a_in = ~a; b_in = ~b; r_in = ~r;   // R9 stray request
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R8", 64'({done, ins_valid, busy}), 64'(3'b100));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 64'({busy, done}), 64'(0));
    check("R1", bus_now(), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 64'({busy, done, ins_valid}), 64'(0));

    for (int v = 0; v < 4; v++) begin
      {a_in, b_in, r_in} = VEC[v];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      steps(VEC[v][3*AW-1:2*AW], VEC[v][2*AW-1:AW], VEC[v][AW-1:0], -1);
      @(negedge clk);
      check("R8", 64'({done, busy, ins_valid}), 64'(0));
      check("R2", bus_now(), 64'(0));
    end

    // R9: stray start in mid-sequence, original addresses must persist
    a_in = 6'd5; b_in = 6'd6; r_in = 6'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    steps(6'd5, 6'd6, 6'd7, 5);
    @(negedge clk);
    check("R9", 64'({done, busy}), 64'(0));

    // R10: start in the done cycle chains a new run
    a_in = 6'd9; b_in = 6'd10; r_in = 6'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    steps(6'd9, 6'd10, 6'd11, -1);
    a_in = 6'd12; b_in = 6'd13; r_in = 6'd14; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10", 64'({busy, done}), 64'(2'b10));
    steps(6'd12, 6'd13, 6'd14, -1);
    @(negedge clk);
    check("R10", 64'({done, busy}), 64'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule